// File: doc/BRIEF.md
# Registered valid/ready skid stage

This block is one register stage placed on a valid/ready stream between a producer and a consumer. Both of its outward handshake signals come straight from flip-flops, so the combinational path from the consumer's ready back to the producer is cut at the stage. It can sit in front of or behind a FIFO, and several copies can be chained port to port with no glue between them.

The parameter `FULL_BW` picks the variant. With `FULL_BW = 1` the stage keeps an output register plus a second "skid" register. It accepts one word on every cycle in which the consumer is ready, and it can absorb the word that arrives in the cycle after the consumer stalls. With `FULL_BW = 0` only the output register exists. Upstream ready is then low for as long as that register is occupied, so a continuous stream moves at one word every two cycles.

Top module: `vr_skid_stage`

## Requirements
- R1: While `rst` is high at a rising edge, `dn_valid` and `up_ready` are low after that edge. After the first rising edge with `rst` low, `up_ready` is high and `dn_valid` is still low.
- R2: A word transfers on an interface at a rising edge where that interface's valid and ready are both high. Every word accepted upstream leaves downstream exactly once, in the order it was accepted, in both modes.
- R3: With `FULL_BW = 1`, `up_valid` and `dn_ready` held high give one downstream transfer on every cycle, with no bubbles.
- R4: With `FULL_BW = 1`, at most two words are accepted while `dn_ready` stays low. If a word is accepted while `dn_valid` is high and `dn_ready` is low, `up_ready` is low in the next cycle.
- R5: With `FULL_BW = 0`, the stage holds at most one word. `up_ready` is low in the cycle after any upstream transfer, so a continuous stream moves at one word every two cycles.
- R6: While `dn_valid` is high and `dn_ready` is low, in the next cycle `dn_valid` stays high and `dn_data` is unchanged.
- R7: `up_ready` changes only at a rising clock edge. A change of `dn_ready` within a cycle does not change `up_ready` until the following edge.
- R8: Two instances connected back to back, with no logic between them, keep order and throughput: one word per cycle when streaming, and four words absorbed when the far end stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| up_data | input | DATA_W | Word offered by the producer |
| up_valid | input | 1 | Producer has a word |
| up_ready | output | 1 | Registered: the stage takes a word at the next edge |
| dn_data | output | DATA_W | Word offered to the consumer |
| dn_valid | output | 1 | Registered: `dn_data` holds a word |
| dn_ready | input | 1 | Consumer takes the word at the next edge |

## Verification
The embedded properties assume that `rst` is high for at least one rising edge before operation. They also assume that `up_valid` and `dn_ready` are at known levels at every edge after that. They make no assumption about how the producer behaves when it is not accepted. The bench changes every input only just after a falling edge, so the inputs are stable across each rising edge. It checks the R7 isolation by toggling `dn_ready` within a cycle. The random phase drives valid and ready independently, and a reference queue per instance checks that nothing is lost or duplicated. A single stream feeds the full-bandwidth, half-bandwidth and chained instances at once. Each instance's queue records only the words that instance itself accepted.

// File: rtl/vr_skid_stage.sv
module vr_skid_stage #(
  parameter int DATA_W  = 16,
  parameter bit FULL_BW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_valid,
  output logic              up_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_valid,
  input  logic              dn_ready
);

  logic              out_v;
  logic [DATA_W-1:0] out_d;
  logic              rdy_q;

  wire up_fire = up_valid & rdy_q;
  wire dn_free = ~out_v | dn_ready;

  assign up_ready = rdy_q;
  assign dn_valid = out_v;
  assign dn_data  = out_d;

  generate
    if (FULL_BW) begin : g_two
      logic              sk_v;
      logic [DATA_W-1:0] sk_d;
      logic              sk_v_nx;

      always_comb begin
        if (sk_v) sk_v_nx = ~dn_free;
        else      sk_v_nx = up_fire & ~dn_free;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          out_v <= 1'b0;
          sk_v  <= 1'b0;
          rdy_q <= 1'b0;
        end else begin
          if (dn_free) out_v <= sk_v | up_fire;
          sk_v  <= sk_v_nx;
          rdy_q <= ~sk_v_nx;
        end
      end

      always_ff @(posedge clk) begin
        if (dn_free) begin
          if (sk_v)         out_d <= sk_d;
          else if (up_fire) out_d <= up_data;
        end
        if (~sk_v & up_fire & ~dn_free) sk_d <= up_data;
      end

      // R4
      skid_full_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready && dn_valid && !dn_ready) |=> !up_ready);

      // R3
      no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        (up_ready && dn_ready) |=> up_ready);

      // R4
      skid_implies_out_chk: assert property (@(posedge clk) disable iff (rst)
        sk_v |-> out_v);
    end else begin : g_one
      logic hold_nx;

      assign hold_nx = up_fire | (out_v & ~dn_ready);

      always_ff @(posedge clk) begin
        if (rst) begin
          out_v <= 1'b0;
          rdy_q <= 1'b0;
        end else begin
          out_v <= hold_nx;
          rdy_q <= ~hold_nx;
        end
      end

      always_ff @(posedge clk) begin
        if (up_fire) out_d <= up_data;
      end

      // R5
      one_entry_stutter_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready) |=> !up_ready);

      // R5
      single_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !(up_ready && dn_valid));
    end
  endgenerate

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dn_valid && !up_ready));

  // R6
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

endmodule

// File: tb/vr_skid_stage_bench.sv
module vr_skid_stage_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst;
  logic [W-1:0] up_data;
  logic         up_valid, dn_ready;

  logic f_ur, f_dv, h_ur, h_dv, c_ur, c_dv, m_v, m_r;
  logic [W-1:0] f_dd, h_dd, c_dd, m_d;

  vr_skid_stage #(.DATA_W(W), .FULL_BW(1'b1)) u_vr_skid_stage (
    .clk(clk), .rst(rst), .up_data(up_data), .up_valid(up_valid), .up_ready(f_ur),
    .dn_data(f_dd), .dn_valid(f_dv), .dn_ready(dn_ready));

  vr_skid_stage #(.DATA_W(W), .FULL_BW(1'b0)) u_half (
    .clk(clk), .rst(rst), .up_data(up_data), .up_valid(up_valid), .up_ready(h_ur),
    .dn_data(h_dd), .dn_valid(h_dv), .dn_ready(dn_ready));

  vr_skid_stage #(.DATA_W(W), .FULL_BW(1'b1)) u_chain0 (
    .clk(clk), .rst(rst), .up_data(up_data), .up_valid(up_valid), .up_ready(c_ur),
    .dn_data(m_d), .dn_valid(m_v), .dn_ready(m_r));

  vr_skid_stage #(.DATA_W(W), .FULL_BW(1'b1)) u_chain1 (
    .clk(clk), .rst(rst), .up_data(m_d), .up_valid(m_v), .up_ready(m_r),
    .dn_data(c_dd), .dn_valid(c_dv), .dn_ready(dn_ready));

  logic [W-1:0] q_f[$], q_h[$], q_c[$];
  int n_tests = 0, n_fail = 0;
  int acc_f = 0, acc_h = 0, acc_c = 0, out_f = 0, out_h = 0, out_c = 0;
  logic [W-1:0] exp_w;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: applies inputs after a falling edge and records accepted words
  task automatic drive(input bit v, input bit r);
    @(negedge clk);
    up_valid = v;
    dn_ready = r;
    up_data  = up_data + 1'b1;
    #1;
    if (!rst) begin
      if (v && f_ur) begin q_f.push_back(up_data); acc_f++; end
      if (v && h_ur) begin q_h.push_back(up_data); acc_h++; end
      if (v && c_ur) begin q_c.push_back(up_data); acc_c++; end
      if (r && f_dv) out_f++;
      if (r && h_dv) out_h++;
      if (r && c_dv) out_c++;
    end
  endtask

  // monitor: compares each downstream transfer with the reference queue (R2, R8)
  always @(negedge clk) begin
    #2;
    if (!rst && dn_ready) begin
      if (f_dv) begin
        exp_w = (q_f.size() > 0) ? q_f.pop_front() : '0;
        check(f_dd == exp_w, "R2 full", int'(f_dd), int'(exp_w));
      end
      if (h_dv) begin
        exp_w = (q_h.size() > 0) ? q_h.pop_front() : '0;
        check(h_dd == exp_w, "R2 half", int'(h_dd), int'(exp_w));
      end
      if (c_dv) begin
        exp_w = (q_c.size() > 0) ? q_c.pop_front() : '0;
        check(c_dd == exp_w, "R8 chain", int'(c_dd), int'(exp_w));
      end
    end
  end

  logic done = 1'b0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int s0, s1, s2, a0, a1, a2;
    logic [W-1:0] snap;
    rst = 1'b1; up_valid = 1'b0; dn_ready = 1'b0; up_data = '0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(!f_dv && !f_ur && !h_dv && !h_ur, "R1 in reset", int'({f_dv, f_ur, h_dv, h_ur}), 0);
    rst = 1'b0;
    #1;
    check(!f_ur && !h_ur, "R1 before first edge", int'({f_ur, h_ur}), 0);
    @(negedge clk);
    #1;
    check(f_ur && h_ur && c_ur, "R1 ready after release", int'({f_ur, h_ur, c_ur}), 7);
    check(!f_dv && !h_dv && !c_dv, "R1 valid after release", int'({f_dv, h_dv, c_dv}), 0);

    // streaming
    repeat (10) drive(1'b1, 1'b1);
    s0 = out_f; s1 = out_h; s2 = out_c;
    repeat (30) drive(1'b1, 1'b1);
    check(out_f - s0 == 30, "R3 full rate", out_f - s0, 30);
    check(out_h - s1 == 15, "R5 half rate", out_h - s1, 15);
    check(out_c - s2 == 30, "R8 chain rate", out_c - s2, 30);

    repeat (5) drive(1'b0, 1'b1);
    check(!f_dv && !h_dv && !c_dv, "R2 drained", int'({f_dv, h_dv, c_dv}), 0);

    // stall with upstream still offering
    a0 = acc_f; a1 = acc_h; a2 = acc_c;
    repeat (2) drive(1'b1, 1'b0);
    snap = f_dd;
    repeat (4) drive(1'b1, 1'b0);
    check(acc_f - a0 == 2, "R4 two absorbed", acc_f - a0, 2);
    check(!f_ur, "R4 ready low when skid full", int'(f_ur), 0);
    check(acc_h - a1 == 1, "R5 one absorbed", acc_h - a1, 1);
    check(acc_c - a2 == 4, "R8 chain absorbed", acc_c - a2, 4);
    check(f_dv && f_dd == snap, "R6 held output", int'(f_dd), int'(snap));

    // registered ready: dn_ready rises mid cycle
    @(negedge clk);
    up_valid = 1'b0;
    dn_ready = 1'b1;
    #1;
    check(!f_ur, "R7 no same-cycle change", int'(f_ur), 0);
    @(negedge clk);
    #1;
    check(f_ur, "R7 ready after edge", int'(f_ur), 1);

    // random traffic
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 6);
    repeat (20) drive(1'b0, 1'b1);
    check(q_f.size() == 0, "R2 full nothing lost", q_f.size(), 0);
    check(q_h.size() == 0, "R2 half nothing lost", q_h.size(), 0);
    check(q_c.size() == 0, "R8 chain nothing lost", q_c.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule